// File: doc/BRIEF.md
# Interrupt Event State Buffer Controller

This block holds a two-bit coalescing state for each of a set of interrupt sources and makes that state reachable through a load/store window. Each source has its own page of 2^SHIFT bytes. The upper address bits select the source, and bits [11:8] of the address select the operation. A store at page offset zero fires the source. Loads retire an event (EOI), read the state, or overwrite it. Every load returns the value the state held just before the access, and the read and the update happen as one step.

The state has two bits. The upper bit P means an event has been delivered and is waiting for its EOI. The lower bit Q means a further event arrived while P was set. Because of this, a source is never queued more than once. Each source also has three input flags: valid, mask and level-sensitive. For level sources the block keeps a "sent" bit per source. When the block accepts a fire it may emit a single-cycle notify pulse that carries the source index.

Top module: `pq_event_ctrl`

## Requirements
- R1: After reset every source reads back state 00. rd_valid, notify_valid and every sent_status bit are low, and req_ready is high from the first clock edge after reset is released.
- R2: The source index is the address shifted right by SHIFT, and the operation is address bits [11:8]. Address bits [7:0] have no effect on the result.
- R3: A fire (store at page offset 0x000) moves state 00 to 10, 10 to 11, and 11 stays 11. Each of these three requests a notify. State 01 stays 01 and requests none.
- R4: notify_valid is high for one cycle, in the cycle after the fire is accepted, and notify_src gives the source index. It happens only when the fire requested a notify and the source's mask bit is 0. A masked fire still changes the state.
- R5: A load at offset 0x000 (EOI) moves 11 to 10 and returns 1. It moves 10 to 00, leaves 00 and 01 unchanged, and returns 0 in those three cases. The result is in rd_data bit 0, and bits 63:1 are zero.
- R6: A load at offset 0x800 returns the state in rd_data[1:0], with P in bit 1 and Q in bit 0, and zeros above. The state does not change.
- R7: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the old state in rd_data[1:0]. They then write address bits [9:8] as the new state (00, 01, 10, 11).
- R8: An access is rejected in any of these cases: req_size is not 8, req_big_endian is 0, the source's valid bit is 0, the index is N_SRC or more, or the offset is not listed above (any nonzero store offset, or loads at 0x100-0x700 and 0x900-0xB00). A rejected load returns all ones and a rejected store is ignored. In both cases the state does not change and no notify is sent.
- R9: A load gives exactly one rd_valid pulse, in the cycle after it is accepted. A store gives none.
- R10: When a notify goes out for a source whose level bit is 1, that source's sent_status bit is set. An accepted EOI on a level source clears it. Sources with level bit 0 never set it.
- R11: States are stored four per byte, with source i in bits [2*(i%4)+1:2*(i%4)] of byte i/4. Updating one source leaves the other three in the same byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address in the window |
| req_size | input | 4 | Access size in bytes |
| req_big_endian | input | 1 | Access byte order is big-endian |
| src_valid | input | N_SRC | Per-source valid flag |
| src_mask | input | N_SRC | Per-source mask flag |
| src_level | input | N_SRC | Per-source level-sensitive flag |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 64 | Load data |
| notify_valid | output | 1 | Single-cycle notify pulse |
| notify_src | output | IDX_W | Source index of the notify |
| sent_status | output | N_SRC | Per-source sent bit for level sources |

## Verification
The assertions assume that the mask, level and valid flags stay constant from the accept edge to the following cycle. They also assume that req_size and req_big_endian are steady while a request is presented. The bench changes flags only while no request is outstanding. It drives each request for exactly one accepted cycle and then waits for the response before it starts the next access.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE = 2'b00;
  localparam pq_t PQ_OFF  = 2'b01;
  localparam pq_t PQ_PEND = 2'b10;
  localparam pq_t PQ_QUED = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FIRE,
    OP_EOI,
    OP_GET,
    OP_SET
  } pq_op_e;

  function automatic pq_t pq_fire_next(input pq_t s);
    case (s)
      PQ_IDLE: pq_fire_next = PQ_PEND;
      PQ_PEND: pq_fire_next = PQ_QUED;
      PQ_QUED: pq_fire_next = PQ_QUED;
      default: pq_fire_next = PQ_OFF;
    endcase
  endfunction

  function automatic logic pq_fire_wants_notify(input pq_t s);
    pq_fire_wants_notify = (s != PQ_OFF);
  endfunction

  function automatic pq_t pq_eoi_next(input pq_t s);
    case (s)
      PQ_IDLE: pq_eoi_next = PQ_IDLE;
      PQ_PEND: pq_eoi_next = PQ_IDLE;
      PQ_QUED: pq_eoi_next = PQ_PEND;
      default: pq_eoi_next = PQ_OFF;
    endcase
  endfunction

  function automatic logic pq_eoi_retrigger(input pq_t s);
    pq_eoi_retrigger = (s == PQ_QUED);
  endfunction

endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SHIFT  = 12,
  parameter int N_SRC  = 12,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [3:0]        size,
  input  logic              big_endian,
  input  logic [N_SRC-1:0]  src_valid,
  output pq_op_e            op,
  output logic [IDX_W-1:0]  idx,
  output logic              bad,
  output pq_t               set_val
);

  localparam int FULL_W = ADDR_W - SHIFT;

  logic [FULL_W-1:0] idx_full;
  logic              in_range;
  logic              src_ok;
  logic [3:0]        page_op;

  assign idx_full = FULL_W'(addr >> SHIFT);
  assign in_range = (32'(idx_full) < N_SRC);
  assign idx      = IDX_W'(idx_full);
  assign page_op  = addr[11:8];
  assign set_val  = addr[9:8];

  always_comb begin
    src_ok = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (in_range && (32'(idx_full) == i)) src_ok = src_valid[i];
    end
  end

  always_comb begin
    op = OP_NONE;
    if (write) begin
      if (page_op == 4'h0) op = OP_FIRE;
    end else begin
      case (page_op)
        4'h0:                      op = OP_EOI;
        4'h8:                      op = OP_GET;
        4'hC, 4'hD, 4'hE, 4'hF:    op = OP_SET;
        default:                   op = OP_NONE;
      endcase
    end
  end

  assign bad = (op == OP_NONE) || (size != 4'd8) || !big_endian || !src_ok;

endmodule

// File: rtl/pq_store.sv
module pq_store
  import pq_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output pq_t              old_pq,
  input  logic             wr_en,
  input  pq_t              new_pq
);

  localparam int N_BYTES = (N_SRC + 3) / 4;

  logic [7:0]       mem [N_BYTES];
  logic [7:0]       cur_byte;
  logic [7:0]       merged;
  logic [IDX_W-1:0] byte_sel;
  logic [1:0]       lane;

  assign byte_sel = idx >> 2;
  assign lane     = idx[1:0];

  always_comb begin
    cur_byte = 8'h00;
    for (int b = 0; b < N_BYTES; b++) begin
      if (32'(byte_sel) == b) cur_byte = mem[b];
    end
  end

  assign old_pq = cur_byte[2*lane +: 2];

  always_comb begin
    merged = cur_byte;
    merged[2*lane +: 2] = new_pq;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= 8'h00;
      else if (wr_en && (32'(byte_sel) == g))
        mem[g] <= merged;
    end
  end

endmodule

// File: rtl/pq_sent_track.sv
module pq_sent_track #(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] sent
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        sent[g] <= 1'b0;
      else if (32'(idx) == g) begin
        if (set_en)      sent[g] <= 1'b1;
        else if (clr_en) sent[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pq_event_ctrl.sv
module pq_event_ctrl
  import pq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SHIFT  = 12,
  parameter int N_SRC  = 12,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic              req_big_endian,
  input  logic [N_SRC-1:0]  src_valid,
  input  logic [N_SRC-1:0]  src_mask,
  input  logic [N_SRC-1:0]  src_level,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              notify_valid,
  output logic [IDX_W-1:0]  notify_src,
  output logic [N_SRC-1:0]  sent_status
);

  pq_op_e           op;
  logic [IDX_W-1:0] idx;
  logic             acc_bad;
  pq_t              set_val;
  pq_t              old_pq;
  pq_t              next_pq;
  logic             fire;
  logic             acc_ok;
  logic             wr_en;
  logic             trig_req;
  logic             mask_bit;
  logic             level_bit;
  logic             notify_fire;
  logic             eoi_evt;
  logic [63:0]      ld_data;

  pq_decode #(
    .ADDR_W(ADDR_W), .SHIFT(SHIFT), .N_SRC(N_SRC), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .write(req_write), .size(req_size),
    .big_endian(req_big_endian), .src_valid(src_valid),
    .op(op), .idx(idx), .bad(acc_bad), .set_val(set_val)
  );

  pq_store #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .old_pq(old_pq),
    .wr_en(wr_en), .new_pq(next_pq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= 1'b1;
  end

  assign fire   = req_valid && req_ready;
  assign acc_ok = fire && !acc_bad;

  always_comb begin
    mask_bit  = 1'b0;
    level_bit = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (32'(idx) == i) begin
        mask_bit  = src_mask[i];
        level_bit = src_level[i];
      end
    end
  end

  always_comb begin
    case (op)
      OP_FIRE: next_pq = pq_fire_next(old_pq);
      OP_EOI:  next_pq = pq_eoi_next(old_pq);
      OP_SET:  next_pq = set_val;
      default: next_pq = old_pq;
    endcase
  end

  assign wr_en       = acc_ok && (op == OP_FIRE || op == OP_EOI || op == OP_SET);
  assign trig_req    = acc_ok && (op == OP_FIRE) && pq_fire_wants_notify(old_pq);
  assign notify_fire = trig_req && !mask_bit;
  assign eoi_evt     = acc_ok && (op == OP_EOI);

  always_comb begin
    if (acc_bad)            ld_data = '1;
    else if (op == OP_EOI)  ld_data = {63'd0, pq_eoi_retrigger(old_pq)};
    else                    ld_data = {62'd0, old_pq};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      notify_valid <= 1'b0;
      notify_src   <= '0;
    end else begin
      rd_valid     <= fire && !req_write;
      if (fire && !req_write) rd_data <= ld_data;
      notify_valid <= notify_fire;
      if (notify_fire) notify_src <= idx;
    end
  end

  pq_sent_track #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_sent (
    .clk(clk), .rst_n(rst_n),
    .set_en(notify_fire && level_bit),
    .clr_en(eoi_evt && level_bit),
    .idx(idx), .sent(sent_status)
  );

endmodule

// File: rtl/pq_event_chk.sv
module pq_event_chk
  import pq_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rd_valid,
  input logic [63:0]      rd_data,
  input logic             notify_valid,
  input logic [IDX_W-1:0] notify_src,
  input logic [N_SRC-1:0] src_mask,
  input logic             acc_bad,
  input pq_t              old_pq,
  input pq_op_e           op
);

  logic             fire;
  logic [N_SRC-1:0] mask_q;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= src_mask;
  end

  AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_write |=> rd_valid); // R9

  AST_RD_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(fire && !req_write)); // R9

  AST_BAD_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_write && acc_bad |=> rd_data == '1); // R8

  AST_NOTIFY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(fire && req_write && !acc_bad)); // R4

  AST_NOTIFY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> !mask_q[notify_src]); // R4

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_write && !acc_bad && old_pq == PQ_OFF |=> !notify_valid); // R3

  AST_EOI_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_write && !acc_bad && op == OP_EOI |=> rd_data[63:1] == '0); // R5

endmodule

bind pq_event_ctrl pq_event_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rd_valid(rd_valid), .rd_data(rd_data),
  .notify_valid(notify_valid), .notify_src(notify_src), .src_mask(src_mask),
  .acc_bad(acc_bad), .old_pq(old_pq), .op(op)
);

// File: tb/pq_event_ctrl_tb.sv
module pq_event_ctrl_tb;

  localparam int ADDR_W = 16;
  localparam int SHIFT  = 12;
  localparam int N_SRC  = 12;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_size = 4'd8;
  logic              req_big_endian = 1'b1;
  logic [N_SRC-1:0]  src_valid = '1;
  logic [N_SRC-1:0]  src_mask = '0;
  logic [N_SRC-1:0]  src_level = '0;
  logic              rd_valid;
  logic [63:0]       rd_data;
  logic              notify_valid;
  logic [IDX_W-1:0]  notify_src;
  logic [N_SRC-1:0]  sent_status;

  int tests = 0;
  int fails = 0;
  logic [1:0] model [N_SRC];

  logic        g_rv, g_nv;
  logic [63:0] g_rd;
  logic [IDX_W-1:0] g_ns;

  always #2 clk = ~clk;

  pq_event_ctrl #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .N_SRC(N_SRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_big_endian(req_big_endian), .src_valid(src_valid),
    .src_mask(src_mask), .src_level(src_level), .rd_valid(rd_valid),
    .rd_data(rd_data), .notify_valid(notify_valid), .notify_src(notify_src),
    .sent_status(sent_status)
  );

  function automatic logic [ADDR_W-1:0] mk(input int s, input int off);
    mk = ADDR_W'((s << SHIFT) | off);
  endfunction

  // expected transitions, restated arithmetically
  function automatic logic [1:0] exp_fire(input logic [1:0] s);
    exp_fire = (s == 2'b01) ? 2'b01 : {1'b1, s[1]};
  endfunction
  function automatic logic [1:0] exp_eoi(input logic [1:0] s);
    exp_eoi = (s == 2'b01) ? 2'b01 : {s[0], 1'b0};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [3:0] sz, input logic be);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    req_size = sz; req_big_endian = be;
    @(negedge clk);
    g_rv = rd_valid; g_rd = rd_data; g_nv = notify_valid; g_ns = notify_src;
    req_valid = 1'b0; req_write = 1'b0; req_size = 4'd8; req_big_endian = 1'b1;
  endtask

  task automatic get_check(input int s, input string req);
    access(1'b0, mk(s, 'h800), 4'd8, 1'b1);
    check(g_rv && g_rd == {62'd0, model[s]}, req, $sformatf("state src %0d", s),
          g_rd, {62'd0, model[s]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] st0;
    logic       exp_n;
    for (int i = 0; i < N_SRC; i++) model[i] = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(req_ready && !rd_valid && !notify_valid && sent_status == '0, "R1",
          "reset outputs", {req_ready, rd_valid, notify_valid, 52'd0, sent_status},
          {1'b1, 63'd0});
    for (int s = 0; s < N_SRC; s++) get_check(s, "R1");

    // R3 R4 R5 R6 R7 R11 sweep over sources and start states
    for (int s = 0; s < N_SRC; s++) begin
      for (int st = 0; st < 4; st++) begin
        src_mask = '0;
        src_mask[s] = (s % 3 == 0);
        access(1'b0, mk(s, 'hC00 | (st << 8)), 4'd8, 1'b1);
        check(g_rv && g_rd == {62'd0, model[s]}, "R7", "set returns old",
              g_rd, {62'd0, model[s]});
        model[s] = 2'(st);
        st0 = model[s];
        access(1'b1, mk(s, 'h000), 4'd8, 1'b1);
        exp_n = (st0 != 2'b01) && !src_mask[s];
        check(g_nv == exp_n && (!exp_n || g_ns == IDX_W'(s)), "R4",
              $sformatf("notify src %0d st %0d", s, st), {g_nv, 59'd0, g_ns},
              {exp_n, 59'd0, IDX_W'(s)});
        check(!g_rv, "R9", "store gives no rd_valid", 64'(g_rv), 64'd0);
        model[s] = exp_fire(st0);
        get_check(s, "R3");
        st0 = model[s];
        access(1'b0, mk(s, 'h000), 4'd8, 1'b1);
        check(g_rv && g_rd == 64'(st0 == 2'b11), "R5", "eoi result",
              g_rd, 64'(st0 == 2'b11));
        model[s] = exp_eoi(st0);
        get_check(s, "R6");
      end
      for (int o = 0; o < N_SRC; o++) get_check(o, "R11");
    end
    src_mask = '0;

    // R9 single-cycle rd_valid
    access(1'b0, mk(0, 'h800), 4'd8, 1'b1);
    @(negedge clk);
    check(!rd_valid, "R9", "rd_valid one cycle", 64'(rd_valid), 64'd0);

    // R8 rejection
    access(1'b0, mk(5, 'hE00), 4'd8, 1'b1);
    model[5] = 2'b10;
    src_valid[5] = 1'b0;
    access(1'b1, mk(5, 'h000), 4'd8, 1'b1);
    check(!g_nv, "R8", "invalid src store notify", 64'(g_nv), 64'd0);
    access(1'b0, mk(5, 'h000), 4'd8, 1'b1);
    check(g_rv && g_rd == '1, "R8", "invalid src load", g_rd, '1);
    src_valid[5] = 1'b1;
    get_check(5, "R8");
    for (int s = N_SRC; s < 16; s++) begin
      access(1'b0, mk(s, 'h800), 4'd8, 1'b1);
      check(g_rd == '1, "R8", "index out of range", g_rd, '1);
    end
    for (int op = 1; op < 12; op++) begin
      if (op != 8) begin
        access(1'b0, mk(5, op << 8), 4'd8, 1'b1);
        check(g_rd == '1, "R8", $sformatf("bad offset %0h", op << 8), g_rd, '1);
      end
    end
    get_check(5, "R8");
    access(1'b1, mk(5, 'h800), 4'd8, 1'b1);
    check(!g_nv, "R8", "store at nonzero offset", 64'(g_nv), 64'd0);
    get_check(5, "R8");
    access(1'b0, mk(5, 'hC00), 4'd4, 1'b1);
    check(g_rd == '1, "R8", "size 4", g_rd, '1);
    access(1'b0, mk(5, 'hC00), 4'd8, 1'b0);
    check(g_rd == '1, "R8", "little endian", g_rd, '1);
    access(1'b1, mk(5, 'h000), 4'd4, 1'b1);
    check(!g_nv, "R8", "short store", 64'(g_nv), 64'd0);
    get_check(5, "R8");

    // R2 low bits ignored, index from upper bits
    access(1'b0, mk(5, 'h8F8), 4'd8, 1'b1);
    check(g_rd == {62'd0, model[5]}, "R2", "low bits ignored", g_rd, {62'd0, model[5]});
    access(1'b0, mk(5, 'hDA7), 4'd8, 1'b1);
    check(g_rd == 64'd2, "R2", "set with low bits", g_rd, 64'd2);
    model[5] = 2'b01;
    get_check(5, "R2");

    // R10 level sources
    src_level[1] = 1'b1;
    src_level[4] = 1'b1;
    src_mask[4]  = 1'b1;
    access(1'b1, mk(1, 'h000), 4'd8, 1'b1);
    check(g_nv && sent_status[1], "R10", "level sent set",
          64'(sent_status), 64'h2);
    access(1'b1, mk(1, 'h000), 4'd8, 1'b1);
    access(1'b0, mk(1, 'h000), 4'd8, 1'b1);
    check(g_rd == 64'd1 && !sent_status[1], "R10", "eoi clears sent",
          {g_rd[31:0], 20'd0, sent_status}, {32'd1, 32'd0});
    access(1'b1, mk(2, 'h000), 4'd8, 1'b1);
    check(g_nv && !sent_status[2], "R10", "edge source not sent",
          64'(sent_status), 64'd0);
    access(1'b1, mk(4, 'h000), 4'd8, 1'b1);
    check(!g_nv && !sent_status[4], "R10", "masked level not sent",
          {g_nv, 51'd0, sent_status}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule